// File: doc/BRIEF.md
# Banked Network Controller Register File

This block is the byte-wide register file of a small Ethernet controller. A host reaches it over a plain bus with an address, a write strobe, write data and combinational read data. The bus address is divided by a fixed address multiplier to form a slot number. There are 32 slots. Slots 8 to 15 form a window, and a two-bit bank field in the configuration slot (slot 7) steers that window to one of three places: the station-address bytes, an eight-byte multicast filter bank or an eight-byte buffer-port bank.

Two interrupt status bytes are set by event inputs from the controller core and cleared by the host, one bit for each written 1. The configuration slot carries a fixed identification nibble that host writes cannot alter. At reset the station-address bytes load from a parameter that holds the same six bytes kept at the start of the address EEPROM. Two slots pass the control and data bits of a serial EEPROM to a separate engine, and that engine can return one data bit at a time.

Top module: `netctl_regfile`

## Requirements
- R1: The slot number is the bus address divided by ADDR_MULT (default 2), truncating, so both addresses 2s and 2s+1 reach slot s. Slots 32 and above are unimplemented.
- R2: After reset every slot reads 0, except these: slot 7 reads {ID_CODE, 4'h0} with ID_CODE default 4'h6, and slots 8 to 13 read the station bytes from STATION_ADDR (default 48'h0A1B2C3D4E5F), with its most significant byte in slot 8.
- R3: Slots 0 (transmit status) and 1 (receive status) clear each stored bit written as 1 and keep the others. In every cycle, tx_evt and rx_evt OR their bits into slots 0 and 1. An event bit wins over a clear of the same bit in the same cycle.
- R4: Slots 2, 3 and 6 are plain read/write bytes.
- R5: In slot 7, bits [7:4] always read ID_CODE, and a write leaves them unchanged. Bits [3:0] take the written data. Bits [3:2] are the bank field: 2'b01 selects the multicast bank, 2'b10 selects the buffer-port bank, and 2'b00 or 2'b11 selects the station bank.
- R6: Slots 8 to 15 read and write byte (slot-8) of the bank the field selects. The multicast and buffer-port banks hold eight independent read/write bytes each. In the station bank, slots 8 to 13 are read/write and slots 14 and 15 read 0 and ignore writes.
- R7: Slot 16 (EEPROM control) stores only bits [3:0] and reads 0 in bits [7:4]. ee_ctl_o shows the stored bits: [0] clock, [1] chip select, [2] data to the device, [3] data-direction flag.
- R8: Slot 17 (EEPROM data) stores only bit 0, which ee_data_o shows. When ee_load_i is high, bit 0 takes ee_bit_i, and this takes priority over a host write in the same cycle.
- R9: Slots 4, 5 and 18 to 31, and every slot from 32 up, read 0, and writes to them change no readable state.
- R10: Reads are combinational from the current address. A write becomes visible only after the rising clock edge on which bus_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (7) | Host byte address before division |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| tx_evt | input | 8 | Transmit event bits set into slot 0 |
| rx_evt | input | 8 | Receive event bits set into slot 1 |
| ee_ctl_o | output | 4 | Stored EEPROM control bits |
| ee_data_o | output | 1 | Stored EEPROM data bit |
| ee_load_i | input | 1 | EEPROM engine load strobe for the data bit |
| ee_bit_i | input | 1 | Data bit returned by the EEPROM engine |

## Verification
A wrong bank field in slot 7 does not corrupt any storage. It shows up on the next read of the window: the read returns bytes from the wrong bank, and a write lands in the wrong bank and only becomes visible when that bank is selected later. A status clear or event merge that goes wrong shows at the very next read of slot 0 or 1. Any write that leaks into a neighbouring slot or into the identification nibble shows in a full read sweep of every address after each write sweep, with the sweep order and bank chosen so that each leak lands in a distinguishable place.

// File: rtl/netctl_pkg.sv
// netctl_pkg: slot numbers, the window geometry and the bank-field
// encoding shared by the register-file modules.
// Assumes a 32-slot byte register space.
package netctl_pkg;

    localparam int SLOTS      = 32;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int WIN_BYTES  = 8;
    localparam int WIN_IDX_W  = $clog2(WIN_BYTES);
    localparam int STA_BYTES  = 6;

    localparam logic [SLOT_W-1:0] S_TXSTAT = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] S_RXSTAT = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] S_TXCTL  = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] S_RXCTL  = SLOT_W'(3);
    localparam logic [SLOT_W-1:0] S_MODE   = SLOT_W'(6);
    localparam logic [SLOT_W-1:0] S_CFG    = SLOT_W'(7);
    localparam logic [SLOT_W-1:0] S_EECTL  = SLOT_W'(16);
    localparam logic [SLOT_W-1:0] S_EEDAT  = SLOT_W'(17);

    typedef enum logic [1:0] {
        BANK_STATION = 2'b00,
        BANK_MCAST   = 2'b01,
        BANK_BUFPORT = 2'b10,
        BANK_STA_ALT = 2'b11
    } bank_e;

    // Number of window banks that hold plain byte storage besides the station bank.
    localparam int EXTRA_BANKS = 2;

endpackage

// File: rtl/netctl_addr_decode.sv
// netctl_addr_decode: turns a host byte address into a slot number.
// Assumes ADDR_MULT >= 1. Addresses whose quotient reaches 32 are
// flagged out of range. in_window marks slots 8..15.
module netctl_addr_decode
    import netctl_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int ADDR_MULT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output logic              in_range,
    output logic              in_window
);

    logic [31:0] quotient;

    // Divide the address by the multiplier and classify the result.
    always_comb begin
        quotient  = 32'(addr) / 32'(ADDR_MULT);
        slot      = quotient[SLOT_W-1:0];
        in_range  = (quotient < 32'(SLOTS));
        in_window = in_range && (slot[SLOT_W-1:WIN_IDX_W] == (SLOT_W-WIN_IDX_W)'(1));
    end

endmodule

// File: rtl/netctl_byte_bank.sv
// netctl_byte_bank: N bytes of register storage with one write port
// and one combinational read port. Each byte resets to its slice of
// INIT, with byte 0 taken from the most significant byte. A read index
// at or above N returns 0, and a write there is dropped.
module netctl_byte_bank #(
    parameter int           N     = 8,
    parameter int           IDX_W = 3,
    parameter logic [N*8-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);

    logic [7:0] mem [N];

    // Reset every byte to its initial value, or write the indexed byte.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)
                mem[i] <= INIT[(N-1-i)*8 +: 8];
            else if (we && (int'(widx) == i))
                mem[i] <= wdata;
        end
    end

    // Return the indexed byte, or 0 past the end of the bank.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (int'(ridx) == i)
                rdata = mem[i];
    end

endmodule

// File: rtl/netctl_regfile.sv
// netctl_regfile: byte register file of a simple Ethernet controller.
// The bank field in slot 7 steers the window at slots 8..15 to the
// station bytes, the multicast bank or the buffer-port bank. Slot 7
// bits [7:4] return a fixed identification nibble. Slots 0 and 1 are
// set by events and cleared by the host. Slots 16 and 17 hand EEPROM
// control and data bits to an external serial engine.
// Assumes one host access per cycle and a synchronous active-low reset.
module netctl_regfile
    import netctl_pkg::*;
#(
    parameter int          ADDR_W       = 7,
    parameter int          ADDR_MULT    = 2,
    parameter logic [3:0]  ID_CODE      = 4'h6,
    parameter logic [47:0] STATION_ADDR = 48'h0A1B2C3D4E5F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        tx_evt,
    input  logic [7:0]        rx_evt,
    output logic [3:0]        ee_ctl_o,
    output logic              ee_data_o,
    input  logic              ee_load_i,
    input  logic              ee_bit_i
);

    localparam logic [WIN_IDX_W-1:0] STA_LAST = WIN_IDX_W'(STA_BYTES - 1);

    logic [SLOT_W-1:0]    slot;
    logic                 in_range;
    logic                 in_window;
    logic                 wr;
    logic [WIN_IDX_W-1:0] win_idx;
    bank_e                bank;

    logic [7:0] tx_stat_q, rx_stat_q;
    logic [7:0] tx_ctl_q, rx_ctl_q, mode_q;
    logic [3:0] cfg_low_q;
    logic [3:0] ee_ctl_q;
    logic       ee_dat_q;
    logic       past_ok;

    logic       sta_we;
    logic [7:0] sta_rd;
    logic       xbank_we [EXTRA_BANKS];
    logic [7:0] xbank_rd [EXTRA_BANKS];

    netctl_addr_decode #(
        .ADDR_W   (ADDR_W),
        .ADDR_MULT(ADDR_MULT)
    ) u_decode (
        .addr     (bus_addr),
        .slot     (slot),
        .in_range (in_range),
        .in_window(in_window)
    );

    // Qualify the write strobe and pick out the window byte and the bank.
    always_comb begin
        wr      = bus_we && in_range;
        win_idx = slot[WIN_IDX_W-1:0];
        bank    = bank_e'(cfg_low_q[3:2]);
    end

    // Steer window writes to the bank the field selects.
    always_comb begin
        sta_we      = wr && in_window && (bank == BANK_STATION || bank == BANK_STA_ALT)
                      && (win_idx <= STA_LAST);
        xbank_we[0] = wr && in_window && (bank == BANK_MCAST);
        xbank_we[1] = wr && in_window && (bank == BANK_BUFPORT);
    end

    netctl_byte_bank #(
        .N    (STA_BYTES),
        .IDX_W(WIN_IDX_W),
        .INIT (STATION_ADDR[STA_BYTES*8-1:0])
    ) u_station (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (sta_we),
        .widx (win_idx),
        .wdata(bus_wdata),
        .ridx (win_idx),
        .rdata(sta_rd)
    );

    // One plain byte bank for the multicast filter and one for the buffer port.
    for (genvar b = 0; b < EXTRA_BANKS; b++) begin : g_xbank
        netctl_byte_bank #(
            .N    (WIN_BYTES),
            .IDX_W(WIN_IDX_W),
            .INIT ('0)
        ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (xbank_we[b]),
            .widx (win_idx),
            .wdata(bus_wdata),
            .ridx (win_idx),
            .rdata(xbank_rd[b])
        );
    end

    // Status bytes: a host write clears its 1 bits, and events set bits afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_stat_q <= '0;
            rx_stat_q <= '0;
        end else begin
            tx_stat_q <= (tx_stat_q & ~((wr && slot == S_TXSTAT) ? bus_wdata : 8'h00)) | tx_evt;
            rx_stat_q <= (rx_stat_q & ~((wr && slot == S_RXSTAT) ? bus_wdata : 8'h00)) | rx_evt;
        end
    end

    // Plain control bytes and the writable low nibble of the configuration slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ctl_q  <= '0;
            rx_ctl_q  <= '0;
            mode_q    <= '0;
            cfg_low_q <= '0;
        end else if (wr) begin
            case (slot)
                S_TXCTL: tx_ctl_q  <= bus_wdata;
                S_RXCTL: rx_ctl_q  <= bus_wdata;
                S_MODE:  mode_q    <= bus_wdata;
                S_CFG:   cfg_low_q <= bus_wdata[3:0];
                default: ;
            endcase
        end
    end

    // EEPROM control bits, and the data bit loaded by the host or by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee_ctl_q <= '0;
            ee_dat_q <= 1'b0;
        end else begin
            if (wr && slot == S_EECTL)
                ee_ctl_q <= bus_wdata[3:0];
            if (ee_load_i)
                ee_dat_q <= ee_bit_i;
            else if (wr && slot == S_EEDAT)
                ee_dat_q <= bus_wdata[0];
        end
    end

    // Drive the EEPROM engine from the stored bits.
    always_comb begin
        ee_ctl_o  = ee_ctl_q;
        ee_data_o = ee_dat_q;
    end

    // Select the read byte for the addressed slot, with 0 for unimplemented slots.
    always_comb begin
        bus_rdata = 8'h00;
        if (in_window) begin
            case (bank)
                BANK_MCAST:   bus_rdata = xbank_rd[0];
                BANK_BUFPORT: bus_rdata = xbank_rd[1];
                default:      bus_rdata = sta_rd;
            endcase
        end else if (in_range) begin
            case (slot)
                S_TXSTAT: bus_rdata = tx_stat_q;
                S_RXSTAT: bus_rdata = rx_stat_q;
                S_TXCTL:  bus_rdata = tx_ctl_q;
                S_RXCTL:  bus_rdata = rx_ctl_q;
                S_MODE:   bus_rdata = mode_q;
                S_CFG:    bus_rdata = {ID_CODE, cfg_low_q};
                S_EECTL:  bus_rdata = {4'h0, ee_ctl_q};
                S_EEDAT:  bus_rdata = {7'h00, ee_dat_q};
                default:  bus_rdata = 8'h00;
            endcase
        end
    end

    // Mark the cycles that have a fully defined previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(bus_we && in_range && slot == S_TXSTAT)
        |-> ((tx_stat_q & $past(bus_wdata) & ~$past(tx_evt)) == 8'h00)); // R3

    AST_CFG_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(bus_we && in_range && slot == S_CFG)
        |-> (cfg_low_q == $past(bus_wdata[3:0]))); // R5

    AST_EE_CTL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(bus_we && in_range && slot == S_EECTL)
        |-> (ee_ctl_o == $past(bus_wdata[3:0]))); // R7

    AST_EE_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(ee_load_i) |-> (ee_data_o == $past(ee_bit_i))); // R8

    AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (bus_rdata == 8'h00)); // R9

endmodule

// File: tb/netctl_regfile_tb.sv
// netctl_regfile_tb_top: runs write and read sweeps over every address
// against a byte-level model of the register map written in the bench.
module netctl_regfile_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 7;
    localparam int          MULT       = 2;
    localparam int          NADDR      = 1 << AW;
    localparam logic [3:0]  ID         = 4'h6;
    localparam logic [47:0] STA        = 48'h0A1B2C3D4E5F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [7:0]    tx_evt = '0;
    logic [7:0]    rx_evt = '0;
    logic [3:0]    ee_ctl_o;
    logic          ee_data_o;
    logic          ee_load_i = 1'b0;
    logic          ee_bit_i = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_base [32];
    logic [7:0] m_mc [8];
    logic [7:0] m_bp [8];

    netctl_regfile dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .tx_evt   (tx_evt),
        .rx_evt   (rx_evt),
        .ee_ctl_o (ee_ctl_o),
        .ee_data_o(ee_data_o),
        .ee_load_i(ee_load_i),
        .ee_bit_i (ee_bit_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_base[i] = 8'h00;
        for (int i = 0; i < 8; i++) begin m_mc[i] = 8'h00; m_bp[i] = 8'h00; end
        m_base[7] = {ID, 4'h0};
        for (int i = 0; i < 6; i++) m_base[8+i] = STA[(5-i)*8 +: 8];
    endtask

    function automatic logic [7:0] model_read(int a);
        int s = a / MULT;
        logic [1:0] bk = m_base[7][3:2];
        if (s >= 32) return 8'h00;
        if (s >= 8 && s <= 15) begin
            if (bk == 2'b01) return m_mc[s-8];
            if (bk == 2'b10) return m_bp[s-8];
            return (s <= 13) ? m_base[s] : 8'h00;
        end
        case (s)
            0, 1, 2, 3, 6, 7, 16, 17: return m_base[s];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(int a, logic [7:0] d);
        int s = a / MULT;
        logic [1:0] bk = m_base[7][3:2];
        if (s >= 32) return;
        if (s >= 8 && s <= 15) begin
            if (bk == 2'b01)      m_mc[s-8] = d;
            else if (bk == 2'b10) m_bp[s-8] = d;
            else if (s <= 13)     m_base[s] = d;
            return;
        end
        case (s)
            0, 1:    m_base[s] = m_base[s] & ~d;
            2, 3, 6: m_base[s] = d;
            7:       m_base[7] = {m_base[7][7:4], d[3:0]};
            16:      m_base[16] = d & 8'h0F;
            17:      m_base[17] = d & 8'h01;
            default: ;
        endcase
    endtask

    function automatic string tag_of(int a);
        int s = a / MULT;
        if (s >= 32) return "R9";
        if (s <= 1) return "R3";
        if (s == 2 || s == 3 || s == 6) return "R4";
        if (s == 7) return "R5";
        if (s >= 8 && s <= 15) return "R6";
        if (s == 16) return "R7";
        if (s == 17) return "R8";
        return "R9";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int a, logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_check(int a, string tag);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic sweep_reads(string prefix);
        for (int a = 0; a < NADDR; a++)
            read_check(a, (prefix == "") ? tag_of(a) : prefix);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset contents of every address
        sweep_reads("R2");
        check("R7", {4'h0, ee_ctl_o}, 8'h00);

        // R1: odd address aliases the even one below it
        bus_write(3*MULT + 1, 8'h5A);
        read_check(3*MULT, "R1");
        read_check(3*MULT + 1, "R1");

        // R10: write not visible before the edge, reads follow the address at once
        @(negedge clk);
        bus_addr = AW'(2*MULT); bus_wdata = 8'hC3; bus_we = 1'b1;
        #1 check("R10", bus_rdata, model_read(2*MULT));
        @(negedge clk);
        bus_we = 1'b0;
        model_write(2*MULT, 8'hC3);
        #1 check("R10", bus_rdata, 8'hC3);
        bus_addr = AW'(3*MULT);
        #1 check("R10", bus_rdata, model_read(3*MULT));

        // R6: each bank selection, write the window, then read everything
        for (int b = 0; b < 4; b++) begin
            bus_write(7*MULT, 8'(8'hF0 | (b << 2) | 1));
            check("R5", {4'h0, m_base[7][3:0]}, 8'(4'(b << 2) | 4'h1));
            for (int s = 8; s < 16; s++)
                bus_write(s*MULT, 8'(s*13 + b*50 + 7));
            sweep_reads("");
        end

        // Full write sweeps over every address with varied data
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < NADDR; a++)
                bus_write(a, 8'(a*37 + p*91 + 5));
            sweep_reads("");
            check("R7", {4'h0, ee_ctl_o}, m_base[16] & 8'h0F);
            check("R8", {7'h00, ee_data_o}, m_base[17] & 8'h01);
        end

        // R3: events set status bits, and an event beats a clear of the same cycle
        bus_write(0, 8'hFF);
        bus_write(1*MULT, 8'hFF);
        @(negedge clk);
        tx_evt = 8'hA5; rx_evt = 8'h3C;
        @(negedge clk);
        tx_evt = 8'h00; rx_evt = 8'h00;
        m_base[0] = 8'hA5; m_base[1] = 8'h3C;
        read_check(0, "R3");
        read_check(1*MULT, "R3");
        @(negedge clk);
        bus_addr = AW'(0); bus_wdata = 8'h05; bus_we = 1'b1; tx_evt = 8'h40;
        @(negedge clk);
        bus_we = 1'b0; tx_evt = 8'h00;
        m_base[0] = 8'hE0;
        read_check(0, "R3");
        @(negedge clk);
        bus_addr = AW'(1*MULT); bus_wdata = 8'hFF; bus_we = 1'b1; rx_evt = 8'h01;
        @(negedge clk);
        bus_we = 1'b0; rx_evt = 8'h00;
        m_base[1] = 8'h01;
        read_check(1*MULT, "R3");

        // R7: upper control bits are dropped
        bus_write(16*MULT, 8'hFF);
        check("R7", {4'h0, ee_ctl_o}, 8'h0F);
        read_check(16*MULT, "R7");

        // R8: engine load beats a host write in the same cycle
        @(negedge clk);
        bus_addr = AW'(17*MULT); bus_wdata = 8'h00; bus_we = 1'b1;
        ee_load_i = 1'b1; ee_bit_i = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; ee_load_i = 1'b0;
        m_base[17] = 8'h01;
        check("R8", {7'h00, ee_data_o}, 8'h01);
        read_check(17*MULT, "R8");
        @(negedge clk);
        ee_load_i = 1'b1; ee_bit_i = 1'b0;
        @(negedge clk);
        ee_load_i = 1'b0;
        m_base[17] = 8'h00;
        check("R8", {7'h00, ee_data_o}, 8'h00);

        // R9: writes to unimplemented slots leave every readable slot unchanged
        bus_write(4*MULT, 8'hFF);
        bus_write(20*MULT, 8'hFF);
        bus_write(NADDR - 1, 8'hFF);
        sweep_reads("R9");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule